// File: doc/BRIEF.md
# Double-Buffered PWM Timer Registers

This block is a single-slope timer/counter core. It has a period register (TOP), a pattern register and a parameter-set number of compare channels. Each of these active registers has a shadow buffer beside it. Software can write either one through a small register port. A write to a buffer marks it pending. The pending value moves into the active register when the counter reaches its update point, unless copying has been locked. A force command copies every pending buffer at once, and it works whether or not copying is locked.

While a buffer is pending, its register pair is busy. Writes to either member of the pair are refused and reported with a one-cycle error pulse. A read of the active member is flagged as not valid. Because of this, software cannot race the hardware copy.

The counter counts up to TOP and restarts at zero, or counts down to zero and restarts at TOP. Each compare output is high while the count is below that channel's compare value. With buffering, a new period takes effect only at the update point. Without buffering, the period takes effect at once, and the counter can overrun.

Top module: `pwm_shadow_timer`

## Requirements
- R1: After reset the count is 0, the counter counts up, copying is unlocked, the period register holds 0xFFFF, all other active and buffer registers hold 0, `buf_valid` is 0 and `wr_err` is 0.
- R2: Address map: 0 control-set, 1 control-clear, 2 period, 3 period buffer, 4 pattern, 5 pattern buffer, 6+2i channel i compare, 7+2i channel i buffer. A write to a buffer whose bit is clear stores the data and sets its `buf_valid` bit (bit 0 period, bit 1 pattern, bit 2+i channel i). A write to an active register whose bit is clear takes effect at the next clock edge.
- R3: While a `buf_valid` bit is 1, a write to its active register or its buffer leaves both unchanged, and `wr_err` is 1 for the cycle after that write. A read of that active register drives `rd_invalid` to 1.
- R4: When copying is unlocked and the update point is reached, each pending buffer is copied into its active register and its valid bit clears on the same edge. Counting up, the update point is count equal to the period; the count then restarts at 0.
- R5: Writing the control-set address with bits [3:2] equal to 3 copies every pending buffer and clears every valid bit, locked or not. Values 0 to 2 in that field change nothing.
- R6: A 1 in bit 0 of a control-set write locks copying, and a 1 in bit 0 of a control-clear write unlocks it. While locked, update points copy nothing. Bit 1 of the same two addresses sets or clears down-counting.
- R7: Counting up, the count is compared with the period on every cycle. If the period is written directly with a value below the count, the counter runs to 0xFFFF and wraps to 0 without any reload.
- R8: With copying unlocked, a new period written to the period buffer takes effect only at the update point, so the count never passes the old period.
- R9: Counting down, the counter reloads the period when it reaches 0. With copying unlocked, a pending period buffer is copied on the next edge without waiting for the update point.
- R10: Compare output i is 1 exactly when the count is below the channel i compare value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (4) | Write address |
| wr_data | input | CW (16) | Write data |
| rd_addr | input | AW (4) | Read address |
| rd_data | output | CW (16) | Read data for rd_addr (combinational) |
| rd_invalid | output | 1 | Read targets an active register with a pending buffer |
| count | output | CW (16) | Counter value |
| wave | output | NCH (4) | Per-channel compare outputs |
| buf_valid | output | NCH+2 (6) | Pending-buffer flags, also the busy flags |
| wr_err | output | 1 | One-cycle pulse after a refused write |

## Verification
The checker watches the following on every cycle:
- the error pulse that follows a refused period write, and the absence of any pulse without a write;
- the clearing of the period flag at an unlocked update point and in unlocked down-counting;
- the total clear on a force command;
- a pattern flag held while locked;
- the up-counting step and the down-counting reload.

Only the bench scenarios can show the following:
- the exact values that reach the active registers;
- the invalid-read flag;
- the 65,505-cycle overrun after a direct period write below the count;
- the claim that a buffered period change never lets the count pass the old TOP;
- compare outputs that follow a newly written compare value.

// File: rtl/pst_pkg.sv
package pst_pkg;
    // register address map
    localparam int ADR_CSET    = 0;
    localparam int ADR_CCLR    = 1;
    localparam int ADR_PER     = 2;
    localparam int ADR_PERBUF  = 3;
    localparam int ADR_PATT    = 4;
    localparam int ADR_PATTBUF = 5;
    localparam int ADR_CC0     = 6;
    // control word fields
    localparam int CTL_LOCK    = 0;
    localparam int CTL_DIR     = 1;
    localparam int CMD_LSB     = 2;
    localparam logic [1:0] CMD_FORCE = 2'd3;
    // pending-flag positions
    localparam int VB_PER      = 0;
    localparam int VB_PATT     = 1;
    localparam int VB_CC0      = 2;
endpackage

// File: rtl/pst_counter.sv
module pst_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] top,
    input  logic          down,
    output logic [CW-1:0] cnt,
    output logic          upd
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_st_t;

    cnt_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        upd = down ? (s_q.cnt == '0) : (s_q.cnt == top);
        if (down) begin
            s_d.cnt = upd ? top : s_q.cnt - 1'b1;
        end else begin
            s_d.cnt = upd ? '0 : s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt = s_q.cnt;
endmodule

// File: rtl/pst_regs.sv
module pst_regs
    import pst_pkg::*;
#(
    parameter int CW  = 16,
    parameter int NCH = 4,
    parameter int AW  = 4,
    parameter int VW  = NCH + 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [AW-1:0]            wr_addr,
    input  logic [CW-1:0]            wr_data,
    input  logic                     upd,
    output logic [CW-1:0]            per,
    output logic [CW-1:0]            perbuf,
    output logic [CW-1:0]            patt,
    output logic [CW-1:0]            pattbuf,
    output logic [NCH-1:0][CW-1:0]   cc,
    output logic [NCH-1:0][CW-1:0]   ccbuf,
    output logic [VW-1:0]            valid,
    output logic                     lock,
    output logic                     dir,
    output logic                     err,
    output logic                     force_upd
);
    typedef struct packed {
        logic [CW-1:0]          per;
        logic [CW-1:0]          perbuf;
        logic [CW-1:0]          patt;
        logic [CW-1:0]          pattbuf;
        logic [NCH-1:0][CW-1:0] cc;
        logic [NCH-1:0][CW-1:0] ccbuf;
        logic [VW-1:0]          valid;
        logic                   lock;
        logic                   dir;
        logic                   err;
    } reg_st_t;

    reg_st_t s_d, s_q;
    logic    hw_copy;

    always_comb begin
        s_d       = s_q;
        s_d.err   = 1'b0;
        force_upd = wr_en && (wr_addr == AW'(ADR_CSET))
                    && (wr_data[CMD_LSB +: 2] == CMD_FORCE);
        hw_copy   = upd && !s_q.lock;

        // buffer to active copies (only for pending buffers)
        if (s_q.valid[VB_PER] &&
            (force_upd || hw_copy || (s_q.dir && !s_q.lock))) begin
            s_d.per           = s_q.perbuf;
            s_d.valid[VB_PER] = 1'b0;
        end
        if (s_q.valid[VB_PATT] && (force_upd || hw_copy)) begin
            s_d.patt           = s_q.pattbuf;
            s_d.valid[VB_PATT] = 1'b0;
        end
        for (int i = 0; i < NCH; i++) begin
            if (s_q.valid[VB_CC0+i] && (force_upd || hw_copy)) begin
                s_d.cc[i]            = s_q.ccbuf[i];
                s_d.valid[VB_CC0+i]  = 1'b0;
            end
        end

        // register writes (refused while the pair is pending)
        if (wr_en) begin
            if (wr_addr == AW'(ADR_CSET)) begin
                if (wr_data[CTL_LOCK]) s_d.lock = 1'b1;
                if (wr_data[CTL_DIR])  s_d.dir  = 1'b1;
            end else if (wr_addr == AW'(ADR_CCLR)) begin
                if (wr_data[CTL_LOCK]) s_d.lock = 1'b0;
                if (wr_data[CTL_DIR])  s_d.dir  = 1'b0;
            end else if (wr_addr == AW'(ADR_PER) || wr_addr == AW'(ADR_PERBUF)) begin
                if (s_q.valid[VB_PER]) begin
                    s_d.err = 1'b1;
                end else if (wr_addr == AW'(ADR_PER)) begin
                    s_d.per = wr_data;
                end else begin
                    s_d.perbuf        = wr_data;
                    s_d.valid[VB_PER] = 1'b1;
                end
            end else if (wr_addr == AW'(ADR_PATT) || wr_addr == AW'(ADR_PATTBUF)) begin
                if (s_q.valid[VB_PATT]) begin
                    s_d.err = 1'b1;
                end else if (wr_addr == AW'(ADR_PATT)) begin
                    s_d.patt = wr_data;
                end else begin
                    s_d.pattbuf        = wr_data;
                    s_d.valid[VB_PATT] = 1'b1;
                end
            end else begin
                for (int i = 0; i < NCH; i++) begin
                    if (wr_addr == AW'(ADR_CC0 + 2*i) ||
                        wr_addr == AW'(ADR_CC0 + 2*i + 1)) begin
                        if (s_q.valid[VB_CC0+i]) begin
                            s_d.err = 1'b1;
                        end else if (wr_addr == AW'(ADR_CC0 + 2*i)) begin
                            s_d.cc[i] = wr_data;
                        end else begin
                            s_d.ccbuf[i]        = wr_data;
                            s_d.valid[VB_CC0+i] = 1'b1;
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.per <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign per     = s_q.per;
    assign perbuf  = s_q.perbuf;
    assign patt    = s_q.patt;
    assign pattbuf = s_q.pattbuf;
    assign cc      = s_q.cc;
    assign ccbuf   = s_q.ccbuf;
    assign valid   = s_q.valid;
    assign lock    = s_q.lock;
    assign dir     = s_q.dir;
    assign err     = s_q.err;
endmodule

// File: rtl/pst_cmp.sv
module pst_cmp #(
    parameter int CW  = 16,
    parameter int NCH = 4
) (
    input  logic [CW-1:0]          cnt,
    input  logic [NCH-1:0][CW-1:0] cmp,
    output logic [NCH-1:0]         wave
);
    for (genvar g = 0; g < NCH; g++) begin : g_chan
        assign wave[g] = (cnt < cmp[g]);
    end
endmodule

// File: rtl/pwm_shadow_timer.sv
module pwm_shadow_timer
    import pst_pkg::*;
#(
    parameter  int CW   = 16,
    parameter  int NCH  = 4,
    localparam int NREG = ADR_CC0 + 2*NCH,
    localparam int AW   = $clog2(NREG),
    localparam int VW   = NCH + 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [CW-1:0]  wr_data,
    input  logic [AW-1:0]  rd_addr,
    output logic [CW-1:0]  rd_data,
    output logic           rd_invalid,
    output logic [CW-1:0]  count,
    output logic [NCH-1:0] wave,
    output logic [VW-1:0]  buf_valid,
    output logic           wr_err
);
    logic [CW-1:0]          per_w, perbuf_w, patt_w, pattbuf_w;
    logic [NCH-1:0][CW-1:0] cc_w, ccbuf_w;
    logic                   lock_w, dir_w, force_w, upd_w;

    pst_counter #(.CW(CW)) i_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .top  (per_w),
        .down (dir_w),
        .cnt  (count),
        .upd  (upd_w)
    );

    pst_regs #(.CW(CW), .NCH(NCH), .AW(AW), .VW(VW)) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .upd      (upd_w),
        .per      (per_w),
        .perbuf   (perbuf_w),
        .patt     (patt_w),
        .pattbuf  (pattbuf_w),
        .cc       (cc_w),
        .ccbuf    (ccbuf_w),
        .valid    (buf_valid),
        .lock     (lock_w),
        .dir      (dir_w),
        .err      (wr_err),
        .force_upd(force_w)
    );

    pst_cmp #(.CW(CW), .NCH(NCH)) i_cmp (
        .cnt (count),
        .cmp (cc_w),
        .wave(wave)
    );

    // read mux
    always_comb begin
        rd_data    = '0;
        rd_invalid = 1'b0;
        if (rd_addr == AW'(ADR_PER)) begin
            rd_data    = per_w;
            rd_invalid = buf_valid[VB_PER];
        end else if (rd_addr == AW'(ADR_PERBUF)) begin
            rd_data = perbuf_w;
        end else if (rd_addr == AW'(ADR_PATT)) begin
            rd_data    = patt_w;
            rd_invalid = buf_valid[VB_PATT];
        end else if (rd_addr == AW'(ADR_PATTBUF)) begin
            rd_data = pattbuf_w;
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (rd_addr == AW'(ADR_CC0 + 2*i)) begin
                    rd_data    = cc_w[i];
                    rd_invalid = buf_valid[VB_CC0+i];
                end else if (rd_addr == AW'(ADR_CC0 + 2*i + 1)) begin
                    rd_data = ccbuf_w[i];
                end
            end
        end
    end
endmodule

// File: rtl/pst_checker.sv
module pst_checker
    import pst_pkg::*;
#(
    parameter int CW  = 16,
    parameter int NCH = 4,
    parameter int AW  = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic [AW-1:0]   wr_addr,
    input logic [NCH+1:0]  buf_valid,
    input logic            wr_err,
    input logic [CW-1:0]   count,
    input logic [CW-1:0]   per_w,
    input logic            lock_w,
    input logic            dir_w,
    input logic            force_w
);
    a_r3_refuse_per: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == AW'(ADR_PER) || wr_addr == AW'(ADR_PERBUF))
         && buf_valid[VB_PER]) |=> wr_err);

    a_r3_no_spurious_err: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> !wr_err);

    a_r4_hw_copy_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_w && !dir_w && buf_valid[VB_PER] && count == per_w)
        |=> !buf_valid[VB_PER]);

    a_r5_force_clears_all: assert property (@(posedge clk) disable iff (!rst_n)
        force_w |=> (buf_valid == '0));

    a_r6_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_w && !force_w && buf_valid[VB_PATT]) |=> buf_valid[VB_PATT]);

    a_r7_up_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_w && count != per_w) |=> (count == CW'($past(count) + 1'b1)));

    a_r9_down_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_w && count == '0) |=> (count == $past(per_w)));

    a_r9_down_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_w && !lock_w && buf_valid[VB_PER]) |=> !buf_valid[VB_PER]);
endmodule

bind pwm_shadow_timer pst_checker #(.CW(CW), .NCH(NCH), .AW(AW)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .buf_valid(buf_valid),
    .wr_err   (wr_err),
    .count    (count),
    .per_w    (per_w),
    .lock_w   (lock_w),
    .dir_w    (dir_w),
    .force_w  (force_w)
);

// File: tb/test_pwm_shadow_timer.sv
`timescale 1ns/1ps
module test_pwm_shadow_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        rd_invalid;
    logic [15:0] count;
    logic [3:0]  wave;
    logic [5:0]  buf_valid;
    logic        wr_err;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    pwm_shadow_timer i_pwm_shadow_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .rd_invalid(rd_invalid), .count(count), .wave(wave),
        .buf_valid(buf_valid), .wr_err(wr_err)
    );

    typedef struct packed {
        logic [3:0]  a;
        logic [15:0] d;
        logic [5:0]  v;
        logic        e;
    } vec_t;

    // write address, data, expected pending flags, expected error pulse
    localparam vec_t VEC [12] = '{
        '{4'd0,  16'h0001, 6'b000000, 1'b0},  // R6 lock copying
        '{4'd2,  16'h0028, 6'b000000, 1'b0},  // R2 direct period 40
        '{4'd3,  16'h003C, 6'b000001, 1'b0},  // R2 period buffer 60
        '{4'd2,  16'h0007, 6'b000001, 1'b1},  // R3 refused
        '{4'd3,  16'h0003, 6'b000001, 1'b1},  // R3 refused
        '{4'd7,  16'h0004, 6'b000101, 1'b0},  // R2 ch0 buffer
        '{4'd6,  16'h0002, 6'b000101, 1'b1},  // R3 ch0 refused
        '{4'd5,  16'h00A5, 6'b000111, 1'b0},  // R2 pattern buffer
        '{4'd13, 16'h0008, 6'b100111, 1'b0},  // R2 ch3 buffer
        '{4'd0,  16'h0005, 6'b100111, 1'b0},  // R5 cmd 1 no-op
        '{4'd0,  16'h000D, 6'b000000, 1'b0},  // R5 force while locked
        '{4'd8,  16'h0006, 6'b000000, 1'b0}   // R2 ch1 direct
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // called at a negedge; returns at the following negedge
    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a, input logic [15:0] exp);
        rd_addr = a;
        #1;
        chk(req, rd_data, exp);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        int n;
        logic [15:0] mx;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 count", count, 0);
        chk("R1 valid", buf_valid, 0);
        chk("R1 err", wr_err, 0);
        chk("R1 wave", wave, 0);
        rd_chk("R1 period", 4'd2, 16'hFFFF);
        rd_chk("R1 pattern", 4'd4, 16'h0000);

        // vector table: R2 R3 R5 R6
        for (int k = 0; k < 12; k++) begin
            wr(VEC[k].a, VEC[k].d);
            chk($sformatf("R2/R3 flags row %0d", k), buf_valid, VEC[k].v);
            chk($sformatf("R3 err row %0d", k), wr_err, VEC[k].e);
        end
        rd_chk("R5 period forced", 4'd2, 16'd60);
        rd_chk("R5 pattern forced", 4'd4, 16'hA5);
        rd_chk("R5 ch0 forced", 4'd6, 16'd4);
        rd_chk("R5 ch3 forced", 4'd12, 16'd8);
        rd_chk("R2 ch1 direct", 4'd8, 16'd6);
        rd_chk("R3 refused ch0 buffer kept", 4'd7, 16'd4);

        // R3 invalid read, R6 lock blocks hardware copy
        wr(4'd3, 16'd6);
        rd_chk("R3 period invalid flag", 4'd2, 16'd60);
        chk("R3 rd_invalid", rd_invalid, 1);
        repeat (70) @(negedge clk);
        chk("R6 locked keeps pending", buf_valid[0], 1);

        // R4 unlocked copy at update point
        wr(4'd1, 16'h0001);
        n = 0;
        while (buf_valid[0] && n < 100) begin @(negedge clk); n++; end
        chk("R4 copied", buf_valid[0], 0);
        chk("R4 count restart", count, 0);
        rd_chk("R4 new period", 4'd2, 16'd6);
        chk("R4 rd_invalid clear", rd_invalid, 0);

        // R8 buffered period change
        n = 0;
        while (count != 16'd5 && n < 20) begin @(negedge clk); n++; end
        wr(4'd3, 16'd2);
        chk("R8 old top still used", count, 6);
        chk("R8 pending", buf_valid[0], 1);
        @(negedge clk);
        chk("R8 restart at old top", count, 0);
        chk("R8 copied", buf_valid[0], 0);
        rd_chk("R8 new period", 4'd2, 16'd2);

        // R10 compare outputs
        wr(4'd6, 16'd1);
        mx = 0;
        for (int k = 0; k < 4; k++) begin
            chk("R10 wave0", wave[0], (count < 16'd1));
            chk("R10 wave2", wave[2], 0);
            chk("R10 wave1", wave[1], 1);
            if (count > mx) mx = count;
            @(negedge clk);
        end
        chk("R8 count bounded", mx, 2);

        // R7 unbuffered overrun
        wr(4'd0, 16'h0001);
        wr(4'd2, 16'd40);
        n = 0;
        while (count != 16'd30 && n < 60) begin @(negedge clk); n++; end
        wr(4'd2, 16'd3);
        chk("R7 no reload", count, 31);
        n = 0;
        while (count != 16'd0 && n < 70000) begin @(negedge clk); n++; end
        chk("R7 wrap cycles", n, 65505);

        // R9 down counting
        wr(4'd0, 16'h0002);
        wr(4'd1, 16'h0001);
        wr(4'd3, 16'd9);
        chk("R9 pending", buf_valid[0], 1);
        @(negedge clk);
        chk("R9 continuous copy", buf_valid[0], 0);
        rd_chk("R9 period", 4'd2, 16'd9);
        n = 0;
        while (count != 16'd0 && n < 20) begin @(negedge clk); n++; end
        @(negedge clk);
        chk("R9 reload top", count, 9);
        @(negedge clk);
        chk("R9 decrement", count, 8);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule